// File: doc/BRIEF.md
# Configurable Pad Multiplexer Bank

This block sits between a group of peripheral signals and a row of bidirectional I/O pad cells. Each peripheral function has three signals: an output value, an output-enable and an input value. Each pad also has three signals. Every pad has its own select register, and that register chooses which of up to `MUX_WIDTH` peripheral functions the pad carries. Column `c` of pad `p` carries function `(p + c) mod NUM_FUNCS`. Because of this rule, one function can be reached from several pads.

On the output side, each pad uses a plain multiplexer that is indexed by its select value. On the input side, each function takes its value from the pads that currently select it. The lowest-numbered such pad wins. Each function is one of three kinds, set by parameter masks: bidirectional, output-only or input-only. The kind decides how the pad's output-enable behaves. A bank built with `MUX_WIDTH = 1` is a dedicated bank. It wires each pad straight to its single function, it has no select registers, and it ignores configuration writes.

Software-side logic writes a select value through a simple strobe port: an enable, a pad index and a 2-bit select value. The new value takes effect at the clock edge that samples the strobe.

Top module: `padmux_bank`

## Requirements
- R1: After reset every select register holds 0, so pad `p` carries function `p mod NUM_FUNCS`.
- R2: A write with `cfgWrEn` high and `cfgWrPad < NUM_PADS` loads `cfgWrSel` into that pad's select register at the sampling clock edge. Outputs change only after that edge. A write with a pad index of `NUM_PADS` or more changes nothing.
- R3: A pad whose select names a bidirectional function drives `padOut` from that function's `funcOut` and `padOe` from that function's `funcOe`. The function index is `(pad + select) mod NUM_FUNCS`.
- R4: A pad whose select names an output-only function (bit set in `OUT_ONLY_MASK`) drives that function's `funcOut` with `padOe` held at 1.
- R5: A pad whose select names an input-only function (bit set in `IN_ONLY_MASK`) drives `padOut` = 0 and `padOe` = 0.
- R6: A pad whose select value is `MUX_WIDTH` or greater drives `padOut` = 0 and `padOe` = 0, so the pad acts as an input.
- R7: A bidirectional or input-only function reads `funcIn` from `padIn` of the lowest-numbered pad whose select currently names it.
- R8: `funcIn` is 0 for a function that no pad selects, and it is always 0 for an output-only function.
- R9: With `MUX_WIDTH = 1`, each pad is wired directly to function `p mod NUM_FUNCS`, the kind rules of R3 to R5 still apply, and configuration writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Select-register write strobe |
| cfgWrPad | input | PAD_W | Index of the pad to write |
| cfgWrSel | input | 2 | New select value |
| funcOut | input | NUM_FUNCS | Output value of each peripheral function |
| funcOe | input | NUM_FUNCS | Output-enable of each peripheral function |
| funcIn | output | NUM_FUNCS | Input value delivered to each function |
| padIn | input | NUM_PADS | Value received from each pad |
| padOut | output | NUM_PADS | Value driven to each pad |
| padOe | output | NUM_PADS | Output-enable of each pad |

## Verification
A select write and live input routing can fall in the same cycle. If a write moves a pad onto a function that a lower-numbered pad already holds, that function's input source must not change. If the write moves the winning pad away, the source must move to the next pad at the edge, not before. The bench provokes this with random writes, including writes to out-of-range indices, in about a third of the cycles, while `padIn`, `funcOut` and `funcOe` change every cycle. A behavioural model updates its select table only at the rising edge. Each cycle the bench judges every pad output and every function input against that model, for a three-wide bank and a dedicated bank driven by the same stimulus.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

  typedef struct packed {
    logic       wrValid;
    logic [7:0] wrPad;
    logic [1:0] wrSel;
  } selWrite_t;

  typedef enum logic [1:0] {
    KIND_BIDIR    = 2'd0,
    KIND_OUT_ONLY = 2'd1,
    KIND_IN_ONLY  = 2'd2,
    KIND_UNUSED   = 2'd3
  } slotKind_e;

  // Function carried by column col of pad pad.
  function automatic int slotFunc(int pad, int col, int numFuncs);
    return (pad + col) % numFuncs;
  endfunction

endpackage

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int PAD_W    = $clog2(NUM_PADS + 1)
) (
  input  logic             cfgWrEn,
  input  logic [PAD_W-1:0] cfgWrPad,
  input  logic [1:0]       cfgWrSel,
  output selWrite_t        selStrobe
);
  localparam logic [PAD_W-1:0] PAD_LIMIT = PAD_W'(NUM_PADS);

  always_comb begin
    selStrobe         = '0;
    selStrobe.wrValid = cfgWrEn && (cfgWrPad < PAD_LIMIT);
    selStrobe.wrPad   = 8'(cfgWrPad);
    selStrobe.wrSel   = cfgWrSel;
  end
endmodule

// File: rtl/padmux_dp.sv
module padmux_dp
  import padmux_pkg::*;
#(
  parameter int                   NUM_PADS      = 8,
  parameter int                   NUM_FUNCS     = 6,
  parameter int                   MUX_WIDTH     = 4,
  parameter logic [NUM_FUNCS-1:0] OUT_ONLY_MASK = '0,
  parameter logic [NUM_FUNCS-1:0] IN_ONLY_MASK  = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  selWrite_t            selStrobe,
  input  logic [NUM_FUNCS-1:0] funcOut,
  input  logic [NUM_FUNCS-1:0] funcOe,
  output logic [NUM_FUNCS-1:0] funcIn,
  input  logic [NUM_PADS-1:0]  padIn,
  output logic [NUM_PADS-1:0]  padOut,
  output logic [NUM_PADS-1:0]  padOe
);

  // Pad-side triplet for one pad that carries function f.
  function automatic logic [1:0] driveFor(int f, logic [NUM_FUNCS-1:0] fo,
                                          logic [NUM_FUNCS-1:0] fe);
    logic [1:0] res;
    res = 2'b00;
    for (int k = 0; k < NUM_FUNCS; k++) begin
      if (k == f) begin
        if (IN_ONLY_MASK[k])       res = 2'b00;
        else if (OUT_ONLY_MASK[k]) res = {fo[k], 1'b1};
        else                       res = {fo[k], fe[k]};
      end
    end
    return res;
  endfunction

  generate
    if (MUX_WIDTH == 1) begin : gDedicated
      logic unusedInputs;
      assign unusedInputs = ^{clk, rstN, selStrobe};

      for (genvar p = 0; p < NUM_PADS; p++) begin : gPad
        localparam int F = p % NUM_FUNCS;
        if (IN_ONLY_MASK[F]) begin : gIn
          assign padOut[p] = 1'b0;
          assign padOe[p]  = 1'b0;
        end else if (OUT_ONLY_MASK[F]) begin : gOut
          assign padOut[p] = funcOut[F];
          assign padOe[p]  = 1'b1;
        end else begin : gBi
          assign padOut[p] = funcOut[F];
          assign padOe[p]  = funcOe[F];
        end
      end

      for (genvar f = 0; f < NUM_FUNCS; f++) begin : gFunc
        if (OUT_ONLY_MASK[f] || f >= NUM_PADS) begin : gNone
          assign funcIn[f] = 1'b0;
        end else begin : gWire
          assign funcIn[f] = padIn[f];
        end
      end
    end else begin : gMuxed
      logic [1:0] selReg [NUM_PADS];

      for (genvar p = 0; p < NUM_PADS; p++) begin : gSel
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            selReg[p] <= 2'd0;
          end else if (selStrobe.wrValid && (int'(selStrobe.wrPad) == p)) begin
            selReg[p] <= selStrobe.wrSel;
          end
        end
      end

      // Straight per-pad output mux.
      always_comb begin
        for (int p = 0; p < NUM_PADS; p++) begin
          logic [1:0] drv;
          if (int'(selReg[p]) >= MUX_WIDTH) begin
            drv = 2'b00;
          end else begin
            drv = driveFor(slotFunc(p, int'(selReg[p]), NUM_FUNCS), funcOut, funcOe);
          end
          padOut[p] = drv[1];
          padOe[p]  = drv[0];
        end
      end

      // Priority input mux: scan high to low so the lowest pad wins.
      always_comb begin
        for (int f = 0; f < NUM_FUNCS; f++) begin
          funcIn[f] = 1'b0;
          if (!OUT_ONLY_MASK[f]) begin
            for (int p = NUM_PADS - 1; p >= 0; p--) begin
              if ((int'(selReg[p]) < MUX_WIDTH) &&
                  (slotFunc(p, int'(selReg[p]), NUM_FUNCS) == f)) begin
                funcIn[f] = padIn[p];
              end
            end
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/padmux_bank.sv
module padmux_bank
  import padmux_pkg::*;
#(
  parameter int                   NUM_PADS      = 8,
  parameter int                   NUM_FUNCS     = 6,
  parameter int                   MUX_WIDTH     = 4,
  parameter logic [NUM_FUNCS-1:0] OUT_ONLY_MASK = NUM_FUNCS'(2),
  parameter logic [NUM_FUNCS-1:0] IN_ONLY_MASK  = NUM_FUNCS'(4),
  parameter int                   PAD_W         = $clog2(NUM_PADS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [PAD_W-1:0]     cfgWrPad,
  input  logic [1:0]           cfgWrSel,
  input  logic [NUM_FUNCS-1:0] funcOut,
  input  logic [NUM_FUNCS-1:0] funcOe,
  output logic [NUM_FUNCS-1:0] funcIn,
  input  logic [NUM_PADS-1:0]  padIn,
  output logic [NUM_PADS-1:0]  padOut,
  output logic [NUM_PADS-1:0]  padOe
);
  selWrite_t selStrobe;

  padmux_ctrl #(.NUM_PADS(NUM_PADS), .PAD_W(PAD_W)) i_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgWrPad (cfgWrPad),
    .cfgWrSel (cfgWrSel),
    .selStrobe(selStrobe)
  );

  padmux_dp #(
    .NUM_PADS     (NUM_PADS),
    .NUM_FUNCS    (NUM_FUNCS),
    .MUX_WIDTH    (MUX_WIDTH),
    .OUT_ONLY_MASK(OUT_ONLY_MASK),
    .IN_ONLY_MASK (IN_ONLY_MASK)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .selStrobe(selStrobe),
    .funcOut  (funcOut),
    .funcOe   (funcOe),
    .funcIn   (funcIn),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe)
  );
endmodule

// File: rtl/padmux_bank_chk.sv
module padmux_bank_chk
  import padmux_pkg::*;
#(
  parameter int                   NUM_PADS      = 8,
  parameter int                   NUM_FUNCS     = 6,
  parameter int                   MUX_WIDTH     = 4,
  parameter logic [NUM_FUNCS-1:0] OUT_ONLY_MASK = '0,
  parameter logic [NUM_FUNCS-1:0] IN_ONLY_MASK  = '0,
  parameter int                   PAD_W         = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWrEn,
  input logic [PAD_W-1:0]     cfgWrPad,
  input logic [1:0]           cfgWrSel,
  input logic [NUM_FUNCS-1:0] funcOut,
  input logic [NUM_FUNCS-1:0] funcOe,
  input logic [NUM_FUNCS-1:0] funcIn,
  input logic [NUM_PADS-1:0]  padIn,
  input logic [NUM_PADS-1:0]  padOut,
  input logic [NUM_PADS-1:0]  padOe
);
  // Shadow of the select table, rebuilt from the write port.
  logic [1:0] shadowSel [NUM_PADS];

  for (genvar p = 0; p < NUM_PADS; p++) begin : gShadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadowSel[p] <= 2'd0;
      else if (MUX_WIDTH > 1 && cfgWrEn && int'(cfgWrPad) == p) shadowSel[p] <= cfgWrSel;
    end
  end

  function automatic slotKind_e kindAt(int pad, logic [1:0] sel);
    int f;
    if (int'(sel) >= MUX_WIDTH) return KIND_UNUSED;
    f = slotFunc(pad, int'(sel), NUM_FUNCS);
    for (int k = 0; k < NUM_FUNCS; k++) begin
      if (k == f) begin
        if (IN_ONLY_MASK[k])  return KIND_IN_ONLY;
        if (OUT_ONLY_MASK[k]) return KIND_OUT_ONLY;
      end
    end
    return KIND_BIDIR;
  endfunction

  function automatic logic bitAt(logic [NUM_FUNCS-1:0] vec, int pad, logic [1:0] sel);
    int f;
    f = slotFunc(pad, int'(sel), NUM_FUNCS);
    for (int k = 0; k < NUM_FUNCS; k++) if (k == f) return vec[k];
    return 1'b0;
  endfunction

  for (genvar p = 0; p < NUM_PADS; p++) begin : gPadChk
    assert_bidir_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
      kindAt(p, shadowSel[p]) == KIND_BIDIR |->
        padOut[p] == bitAt(funcOut, p, shadowSel[p]) && padOe[p] == bitAt(funcOe, p, shadowSel[p]));
    assert_out_only_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
      kindAt(p, shadowSel[p]) == KIND_OUT_ONLY |-> padOe[p]);
    assert_in_only_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
      kindAt(p, shadowSel[p]) == KIND_IN_ONLY |-> !padOe[p] && !padOut[p]);
    assert_unused_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
      kindAt(p, shadowSel[p]) == KIND_UNUSED |-> !padOe[p] && !padOut[p]);
  end

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : gFuncChk
    if (OUT_ONLY_MASK[f]) begin : gOutOnly
      assert_out_only_in_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
        !funcIn[f]);
    end
  end
endmodule

bind padmux_bank padmux_bank_chk #(
  .NUM_PADS     (NUM_PADS),
  .NUM_FUNCS    (NUM_FUNCS),
  .MUX_WIDTH    (MUX_WIDTH),
  .OUT_ONLY_MASK(OUT_ONLY_MASK),
  .IN_ONLY_MASK (IN_ONLY_MASK),
  .PAD_W        (PAD_W)
) i_chk (.*);

// File: tb/test_padmux_bank.sv
`timescale 1ns/1ps
module test_padmux_bank;
  localparam int NP = 8;
  localparam int NF = 6;
  localparam int PW = 4;
  localparam logic [NF-1:0] OUTM = 6'b000010;
  localparam logic [NF-1:0] INM  = 6'b000100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN;
  logic          cfgWrEn;
  logic [PW-1:0] cfgWrPad;
  logic [1:0]    cfgWrSel;
  logic [NF-1:0] funcOut, funcOe, funcInA, funcInB;
  logic [NP-1:0] padIn, padOutA, padOeA, padOutB, padOeB;

  padmux_bank #(.NUM_PADS(NP), .NUM_FUNCS(NF), .MUX_WIDTH(3),
                .OUT_ONLY_MASK(OUTM), .IN_ONLY_MASK(INM)) i_padmux_bank (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrPad(cfgWrPad), .cfgWrSel(cfgWrSel),
    .funcOut(funcOut), .funcOe(funcOe), .funcIn(funcInA),
    .padIn(padIn), .padOut(padOutA), .padOe(padOeA));

  padmux_bank #(.NUM_PADS(NP), .NUM_FUNCS(NF), .MUX_WIDTH(1),
                .OUT_ONLY_MASK(OUTM), .IN_ONLY_MASK(INM)) i_padmux_bank_w1 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrPad(cfgWrPad), .cfgWrSel(cfgWrSel),
    .funcOut(funcOut), .funcOe(funcOe), .funcIn(funcInB),
    .padIn(padIn), .padOut(padOutB), .padOe(padOeB));

  int  modelSel [NP];
  bit  anyWrite;
  int  passCnt  = 0;
  int  totalCnt = 0;
  bit  done     = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NP; p++) modelSel[p] = 0;
      anyWrite = 0;
    end else if (cfgWrEn && int'(cfgWrPad) < NP) begin
      modelSel[int'(cfgWrPad)] = int'(cfgWrSel);
      anyWrite = 1;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    totalCnt++;
    if (act !== exp) $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    else passCnt++;
  endtask

  // kind: 0 bidir, 1 output-only, 2 input-only, 3 unused slot
  function automatic int kindOf(int mw, int p, int s);
    int f;
    if (s >= mw) return 3;
    f = (p + s) % NF;
    if (INM[f])  return 2;
    if (OUTM[f]) return 1;
    return 0;
  endfunction

  task automatic checkBank(int mw, logic [NP-1:0] po, logic [NP-1:0] poe, logic [NF-1:0] fi);
    for (int p = 0; p < NP; p++) begin
      int s, f, k;
      logic eo, ee;
      string tag;
      s = (mw == 1) ? 0 : modelSel[p];
      f = (p + s) % NF;
      k = kindOf(mw, p, s);
      case (k)
        0: begin eo = funcOut[f]; ee = funcOe[f]; tag = "R3"; end
        1: begin eo = funcOut[f]; ee = 1'b1;      tag = "R4"; end
        2: begin eo = 1'b0;       ee = 1'b0;      tag = "R5"; end
        default: begin eo = 1'b0; ee = 1'b0;      tag = "R6"; end
      endcase
      if (!anyWrite) tag = "R1";
      if (mw == 1) tag = "R9";
      chk(tag, $sformatf("padOut[%0d]", p), po[p], eo);
      chk(tag, $sformatf("padOe[%0d]", p), poe[p], ee);
    end
    for (int f = 0; f < NF; f++) begin
      logic ei;
      string tag;
      ei = 1'b0;
      tag = "R8";
      if (!OUTM[f]) begin
        for (int p = NP - 1; p >= 0; p--) begin
          int s;
          s = (mw == 1) ? 0 : modelSel[p];
          if (s < mw && (p + s) % NF == f) begin ei = padIn[p]; tag = "R7"; end
        end
      end
      if (mw == 1) tag = "R9";
      chk(tag, $sformatf("funcIn[%0d]", f), fi[f], ei);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    totalCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 0; cfgWrEn = 0; cfgWrPad = '0; cfgWrSel = '0;
    funcOut = '0; funcOe = '0; padIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    funcOut = 6'b111111; funcOe = 6'b001000; padIn = 8'hA5;
    #1;
    checkBank(3, padOutA, padOeA, funcInA);   // R1 reset mapping
    // R2: write pad 3 to column 1 (function 4); before the edge function 3 still drives.
    cfgWrEn = 1; cfgWrPad = 4'd3; cfgWrSel = 2'd1;
    #1;
    chk("R2", "padOe[3] before edge", padOeA[3], 1'b1);
    @(negedge clk);
    cfgWrEn = 0;
    #1;
    chk("R2", "padOe[3] after edge", padOeA[3], 1'b0);
    // R2: out-of-range pad index is ignored.
    cfgWrEn = 1; cfgWrPad = 4'd8; cfgWrSel = 2'd2;
    @(negedge clk);
    cfgWrEn = 0;
    #1;
    checkBank(3, padOutA, padOeA, funcInA);
    // R7: pads 0 (col 0) and 5 (col 1) both on function 0; pad 0 wins.
    cfgWrEn = 1; cfgWrPad = 4'd5; cfgWrSel = 2'd1;
    @(negedge clk);
    cfgWrEn = 0; padIn = 8'b0010_0000;
    #1;
    chk("R7", "funcIn[0] priority", funcInA[0], 1'b0);
    // Random traffic with concurrent writes.
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      funcOut = NF'($urandom);
      funcOe  = NF'($urandom);
      padIn   = NP'($urandom);
      cfgWrEn = ($urandom % 3) == 0;
      cfgWrPad = PW'($urandom % 10);
      cfgWrSel = 2'($urandom);
      #1;
      checkBank(3, padOutA, padOeA, funcInA);
      checkBank(1, padOutB, padOeB, funcInB);
    end
    finishRun();
  end
endmodule